// File: doc/BRIEF.md
# UART Multiprocessor Receive Mute Controller

This block sits behind a UART receiver core on a shared serial bus where many nodes listen to one sender. The core reports one event per received frame (frame done, with the received byte and its error bits) and one event per idle frame on the line. The controller decides whether each event reaches the rest of the chip. While the node is muted, every such event is silently dropped: no data-valid, no status flag and no interrupt. A status output tells software whether the receiver is currently muted.

Software turns the mute feature on with an enable input and picks one of two wake methods. In idle-line mode (wake select = 0), software forces mute with a one-cycle request strobe, and the node wakes on the next idle frame. That idle frame itself raises no idle flag. In address-mark mode (wake select = 1), a byte whose MSB is 1 is an address frame, and its lower bits are compared with the node address. A match wakes the node. A mismatch while awake mutes it. Address frames are consumed and never delivered. The strobe also forces mute in this mode.

A three-state machine holds the mode: `ST_OFF` (feature disabled), `ST_LISTEN` (enabled, awake) and `ST_MUTED`. Its transitions are:
- enable (`ST_OFF`→`ST_LISTEN`);
- disable (any state→`ST_OFF`);
- request (`ST_LISTEN`→`ST_MUTED` on the strobe);
- reject (`ST_LISTEN`→`ST_MUTED` on a mismatching address frame);
- idle wake (`ST_MUTED`→`ST_LISTEN` on an idle frame, idle-line mode);
- address wake (`ST_MUTED`→`ST_LISTEN` on a matching address frame, address-mark mode).

Top module: `uart_mute_ctrl`

## Requirements
- R1: After reset, `rx_wake`, `data_valid`, `stat_err`, `stat_idle`, `irq_rx` and `irq_idle` are all 0.
- R2: While `mute_en` is 0, the block never mutes and `mute_req` has no effect. Every frame is delivered: `data_valid` is 1 in the cycle after `frame_done`, and `rx_wake` stays 0.
- R3: In idle-line mode, with the feature enabled and the node awake, a `mute_req` pulse sets `rx_wake` in the next cycle.
- R4: While muted, a frame or an idle event raises none of `data_valid`, `stat_err` or `stat_idle` in the following cycle.
- R5: While muted, `irq_rx` and `irq_idle` are held at 0.
- R6: In idle-line mode, an idle event while muted clears `rx_wake` in the next cycle, and `stat_idle` stays 0 for that event.
- R7: In address-mark mode, a frame with bit 7 = 1 whose bits 6..0 equal `node_addr` clears `rx_wake` in the next cycle. That byte does not assert `data_valid`.
- R8: In address-mark mode while awake, a frame with bit 7 = 1 whose bits 6..0 differ from `node_addr` sets `rx_wake` in the next cycle. That byte does not assert `data_valid`.
- R9: In address-mark mode, a `mute_req` pulse while awake sets `rx_wake` in the next cycle.
- R10: Clearing `mute_en` clears `rx_wake` on the next clock. If `mute_en` is low for a single cycle and then high again, the node ends up awake and the strobe works again afterwards.
- R11: While awake, a frame gives `data_valid`, `data_out` equal to the byte, and `stat_err` equal to the error bits, all in the next cycle. The error bits are: bit 0 overrun, bit 1 framing, bit 2 noise, bit 3 parity. `irq_rx` is 1 in that cycle. An idle event gives `stat_idle` and `irq_idle` in the next cycle.
- R12: In address-mark mode, data frames (bit 7 = 0) received while muted do not wake the node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mute_en | input | 1 | Mute feature enable |
| wake_sel | input | 1 | Wake method: 0 idle line, 1 address mark |
| mute_req | input | 1 | One-cycle request to enter mute |
| node_addr | input | DATA_W-1 | Address of this node |
| frame_done | input | 1 | Receiver core finished a frame |
| idle_det | input | 1 | Receiver core saw an idle frame |
| rx_data | input | DATA_W | Received byte, valid with frame_done |
| rx_err | input | ERR_W | Error bits of the frame, valid with frame_done |
| rx_wake | output | 1 | 1 while muted |
| data_valid | output | 1 | Gated data-ready pulse |
| data_out | output | DATA_W | Last delivered byte |
| stat_err | output | ERR_W | Gated error flags (pulses) |
| stat_idle | output | 1 | Gated idle flag (pulse) |
| irq_rx | output | 1 | Gated receive interrupt request |
| irq_idle | output | 1 | Gated idle interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit byte, a 7-bit node address and four error bits. Bit 7 is therefore the mark bit, and the address space is small enough that the bench can use both a matching address and a near-miss that differs in one bit. These values bring every state transition within reach: address frames, data frames with the MSB clear, and each error bit alone or combined. They also allow same-cycle collisions, such as a strobe arriving together with a frame, and a single-cycle drop of the enable.

// File: rtl/uart_mute_pkg.sv
package uart_mute_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_LISTEN = 2'd1,
        ST_MUTED  = 2'd2
    } mute_state_e;

    localparam logic WAKE_IDLE = 1'b0;
    localparam logic WAKE_ADDR = 1'b1;

endpackage

// File: rtl/uart_mute_addr_cmp.sv
module uart_mute_addr_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-2:0] node_addr,
    output logic              is_mark,
    output logic              addr_hit
);
    localparam int MARK_BIT = DATA_W - 1;

    always_comb begin
        is_mark  = rx_data[MARK_BIT];
        addr_hit = (rx_data[MARK_BIT-1:0] == node_addr);
    end
endmodule

// File: rtl/uart_mute_fsm.sv
module uart_mute_fsm
    import uart_mute_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mute_en,
    input  logic        wake_sel,
    input  logic        mute_req,
    input  logic        frame_done,
    input  logic        idle_det,
    input  logic        is_mark,
    input  logic        addr_hit,
    output mute_state_e state_q,
    output logic        muted
);
    mute_state_e state_d;
    logic        addr_frame;

    always_comb addr_frame = frame_done && is_mark && (wake_sel == WAKE_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!mute_en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_LISTEN;
                ST_LISTEN: begin
                    if (mute_req)                    state_d = ST_MUTED;
                    else if (addr_frame && !addr_hit) state_d = ST_MUTED;
                end
                ST_MUTED: begin
                    if ((wake_sel == WAKE_IDLE) && idle_det) state_d = ST_LISTEN;
                    else if (addr_frame && addr_hit)         state_d = ST_LISTEN;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_MUTED: muted = 1'b1;
            default:  muted = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_mute_gate.sv
module uart_mute_gate
    import uart_mute_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mute_state_e       state_q,
    input  logic              wake_sel,
    input  logic              frame_done,
    input  logic              idle_det,
    input  logic              is_mark,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out,
    output logic [ERR_W-1:0]  stat_err,
    output logic              stat_idle,
    output logic              irq_rx,
    output logic              irq_idle
);
    logic consumed;
    logic pass_frame;
    logic pass_idle;
    logic [ERR_W-1:0] err_d;

    always_comb begin
        consumed   = (state_q != ST_OFF) && (wake_sel == WAKE_ADDR) && is_mark;
        pass_frame = frame_done && (state_q != ST_MUTED) && !consumed;
        pass_idle  = idle_det && (state_q != ST_MUTED);
    end

    for (genvar gi = 0; gi < ERR_W; gi++) begin : g_err
        always_comb err_d[gi] = pass_frame && rx_err[gi];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_valid <= 1'b0;
            data_out   <= '0;
            stat_err   <= '0;
            stat_idle  <= 1'b0;
            irq_rx     <= 1'b0;
            irq_idle   <= 1'b0;
        end else begin
            data_valid <= pass_frame;
            if (pass_frame) data_out <= rx_data;
            stat_err   <= err_d;
            stat_idle  <= pass_idle;
            irq_rx     <= pass_frame;
            irq_idle   <= pass_idle;
        end
    end
endmodule

// File: rtl/uart_mute_ctrl.sv
module uart_mute_ctrl
    import uart_mute_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_en,
    input  logic              wake_sel,
    input  logic              mute_req,
    input  logic [DATA_W-2:0] node_addr,
    input  logic              frame_done,
    input  logic              idle_det,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    output logic              rx_wake,
    output logic              data_valid,
    output logic [DATA_W-1:0] data_out,
    output logic [ERR_W-1:0]  stat_err,
    output logic              stat_idle,
    output logic              irq_rx,
    output logic              irq_idle
);
    mute_state_e state_q;
    logic        is_mark;
    logic        addr_hit;

    uart_mute_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rx_data  (rx_data),
        .node_addr(node_addr),
        .is_mark  (is_mark),
        .addr_hit (addr_hit)
    );

    uart_mute_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mute_en   (mute_en),
        .wake_sel  (wake_sel),
        .mute_req  (mute_req),
        .frame_done(frame_done),
        .idle_det  (idle_det),
        .is_mark   (is_mark),
        .addr_hit  (addr_hit),
        .state_q   (state_q),
        .muted     (rx_wake)
    );

    uart_mute_gate #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_q   (state_q),
        .wake_sel  (wake_sel),
        .frame_done(frame_done),
        .idle_det  (idle_det),
        .is_mark   (is_mark),
        .rx_data   (rx_data),
        .rx_err    (rx_err),
        .data_valid(data_valid),
        .data_out  (data_out),
        .stat_err  (stat_err),
        .stat_idle (stat_idle),
        .irq_rx    (irq_rx),
        .irq_idle  (irq_idle)
    );
endmodule

// File: rtl/uart_mute_ctrl_chk.sv
module uart_mute_ctrl_chk
    import uart_mute_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mute_en,
    input logic              wake_sel,
    input logic              mute_req,
    input logic              frame_done,
    input logic              idle_det,
    input logic [DATA_W-1:0] rx_data,
    input mute_state_e       state_q,
    input logic              rx_wake,
    input logic              data_valid,
    input logic [ERR_W-1:0]  stat_err,
    input logic              stat_idle,
    input logic              irq_rx,
    input logic              irq_idle
);
    assert_muted_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wake |=> (!data_valid && (stat_err == '0) && !stat_idle));

    assert_muted_no_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wake |=> (!irq_rx && !irq_idle));

    assert_disable_unmutes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_en |=> !rx_wake);

    assert_off_never_mutes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> !rx_wake);

    assert_request_mutes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN && mute_en && mute_req) |=> rx_wake);

    assert_idle_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && mute_en && !wake_sel && idle_det) |=> (!rx_wake && !stat_idle));

    assert_data_keeps_mute_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MUTED && mute_en && wake_sel && frame_done && !rx_data[DATA_W-1]) |=> rx_wake);
endmodule

bind uart_mute_ctrl uart_mute_ctrl_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mute_en   (mute_en),
    .wake_sel  (wake_sel),
    .mute_req  (mute_req),
    .frame_done(frame_done),
    .idle_det  (idle_det),
    .rx_data   (rx_data),
    .state_q   (state_q),
    .rx_wake   (rx_wake),
    .data_valid(data_valid),
    .stat_err  (stat_err),
    .stat_idle (stat_idle),
    .irq_rx    (irq_rx),
    .irq_idle  (irq_idle)
);

// File: tb/uart_mute_ctrl_tb.sv
`timescale 1ns/1ps
module uart_mute_ctrl_tb;
    localparam int DATA_W = 8;
    localparam int ERR_W  = 4;
    localparam logic [6:0] MY_ADDR = 7'h15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mute_en = 1'b0, wake_sel = 1'b0, mute_req = 1'b0;
    logic [DATA_W-2:0] node_addr = MY_ADDR;
    logic frame_done = 1'b0, idle_det = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic [ERR_W-1:0]  rx_err = '0;
    logic rx_wake, data_valid, stat_idle, irq_rx, irq_idle;
    logic [DATA_W-1:0] data_out;
    logic [ERR_W-1:0]  stat_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    uart_mute_ctrl #(.DATA_W(DATA_W), .ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .mute_en(mute_en), .wake_sel(wake_sel),
        .mute_req(mute_req), .node_addr(node_addr), .frame_done(frame_done),
        .idle_det(idle_det), .rx_data(rx_data), .rx_err(rx_err),
        .rx_wake(rx_wake), .data_valid(data_valid), .data_out(data_out),
        .stat_err(stat_err), .stat_idle(stat_idle), .irq_rx(irq_rx),
        .irq_idle(irq_idle)
    );

    // behavioural reference: 0 disabled, 1 awake, 2 muted
    int m_mode = 0;
    logic e_wake = 0, e_dv = 0, e_idle = 0, e_irx = 0, e_iidle = 0;
    logic [DATA_W-1:0] e_data = '0;
    logic [ERR_W-1:0]  e_err = '0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_mode <= 0; e_wake <= 0; e_dv <= 0; e_idle <= 0;
            e_irx <= 0; e_iidle <= 0; e_err <= '0; e_data <= '0;
        end else begin
            automatic bit mark   = rx_data[7];
            automatic bit hit    = (rx_data[6:0] == node_addr);
            automatic bit eaten  = (m_mode != 0) && wake_sel && mark;
            automatic bit fr_ok  = frame_done && (m_mode != 2) && !eaten;
            automatic bit id_ok  = idle_det && (m_mode != 2);
            automatic int nxt    = m_mode;
            e_dv    <= fr_ok;
            e_irx   <= fr_ok;
            e_err   <= fr_ok ? rx_err : '0;
            if (fr_ok) e_data <= rx_data;
            e_idle  <= id_ok;
            e_iidle <= id_ok;
            if (!mute_en) nxt = 0;
            else if (m_mode == 0) nxt = 1;
            else if (m_mode == 1) begin
                if (mute_req) nxt = 2;
                else if (wake_sel && frame_done && mark && !hit) nxt = 2;
            end else begin
                if (!wake_sel && idle_det) nxt = 1;
                else if (wake_sel && frame_done && mark && hit) nxt = 1;
            end
            m_mode <= nxt;
            e_wake <= (nxt == 2);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one clock, then compare every output against the model
    task automatic cyc();
        @(negedge clk);
        chk(rx_wake == e_wake, "R3 rx_wake vs model", rx_wake, e_wake);
        chk(data_valid == e_dv, "R4 data_valid vs model", data_valid, e_dv);
        chk(stat_err == e_err, "R4 stat_err vs model", stat_err, e_err);
        chk(stat_idle == e_idle, "R4 stat_idle vs model", stat_idle, e_idle);
        chk(irq_rx == e_irx && irq_idle == e_iidle, "R5 irqs vs model",
            {irq_rx, irq_idle}, {e_irx, e_iidle});
        if (e_dv) chk(data_out == e_data, "R11 data_out vs model", data_out, e_data);
    endtask

    task automatic frame(input logic [7:0] d, input logic [3:0] e);
        rx_data = d; rx_err = e; frame_done = 1'b1;
        cyc();
        frame_done = 1'b0; rx_err = '0;
    endtask

    task automatic idle_ev();
        idle_det = 1'b1;
        cyc();
        idle_det = 1'b0;
    endtask

    task automatic req();
        mute_req = 1'b1;
        cyc();
        mute_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        chk({rx_wake, data_valid, stat_err, stat_idle, irq_rx, irq_idle} == '0,
            "R1 reset outputs", {rx_wake, data_valid, stat_err, stat_idle}, 0);

        // feature off
        req();
        chk(rx_wake == 1'b0, "R2 request ignored while disabled", rx_wake, 0);
        frame(8'hA5, 4'h0);
        chk(data_valid && data_out == 8'hA5, "R2 frame delivered while disabled", data_out, 8'hA5);

        // idle-line mode
        mute_en = 1'b1; wake_sel = 1'b0;
        cyc(); cyc();
        frame(8'h3C, 4'b1001);
        chk(data_valid && stat_err == 4'b1001 && irq_rx, "R11 frame with errors", stat_err, 4'b1001);
        idle_ev();
        chk(stat_idle && irq_idle, "R11 idle flag while awake", stat_idle, 1);
        req();
        chk(rx_wake == 1'b1, "R3 request mutes", rx_wake, 1);
        frame(8'h11, 4'hF);
        chk(!data_valid && stat_err == 0, "R4 muted frame dropped", data_valid, 0);
        chk(!irq_rx, "R5 no irq while muted", irq_rx, 0);
        frame(8'h95, 4'h0);
        chk(rx_wake == 1'b1, "R4 address byte ignored in idle mode", rx_wake, 1);
        idle_ev();
        chk(!rx_wake && !stat_idle && !irq_idle, "R6 idle wake without flag", {rx_wake, stat_idle}, 0);
        frame(8'h22, 4'h2);
        chk(data_valid && data_out == 8'h22, "R6 delivery resumes", data_out, 8'h22);
        // strobe colliding with a frame: frame delivered, then muted
        mute_req = 1'b1;
        frame(8'h44, 4'h0);
        mute_req = 1'b0;
        chk(data_valid && rx_wake, "R3 strobe with frame", {data_valid, rx_wake}, 3);
        idle_ev();

        // address-mark mode
        wake_sel = 1'b1;
        cyc();
        frame({1'b1, MY_ADDR ^ 7'h01}, 4'h0);
        chk(rx_wake && !data_valid, "R8 mismatch address mutes", {rx_wake, data_valid}, 2);
        frame({1'b0, MY_ADDR}, 4'h0);
        chk(rx_wake && !data_valid, "R12 data byte keeps mute", {rx_wake, data_valid}, 2);
        idle_ev();
        chk(rx_wake && !stat_idle, "R12 idle does not wake in address mode", rx_wake, 1);
        frame({1'b1, MY_ADDR}, 4'h0);
        chk(!rx_wake && !data_valid, "R7 matching address wakes, consumed", {rx_wake, data_valid}, 0);
        frame(8'h5A, 4'h4);
        chk(data_valid && data_out == 8'h5A && stat_err == 4'h4, "R7 data after wake", data_out, 8'h5A);
        frame({1'b1, MY_ADDR}, 4'h0);
        chk(!rx_wake && !data_valid, "R7 match while awake consumed", {rx_wake, data_valid}, 0);
        req();
        chk(rx_wake == 1'b1, "R9 strobe mutes in address mode", rx_wake, 1);

        // disable and quick toggle
        mute_en = 1'b0;
        cyc();
        chk(rx_wake == 1'b0, "R10 disable clears wake flag", rx_wake, 0);
        mute_en = 1'b1;
        cyc();
        req();
        chk(rx_wake == 1'b1, "R10 mute again after re-enable", rx_wake, 1);
        mute_en = 1'b0;
        cyc();
        mute_en = 1'b1;
        cyc(); cyc();
        chk(rx_wake == 1'b0, "R10 quick toggle ends awake", rx_wake, 0);
        frame(8'h66, 4'h0);
        chk(data_valid && data_out == 8'h66, "R10 delivery after toggle", data_out, 8'h66);
        req();
        chk(rx_wake == 1'b1, "R10 strobe works after toggle", rx_wake, 1);
        cyc();
        finish_run();
    end
endmodule